// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-side controller of a two-wire serial EEPROM. It runs entirely in the system clock domain. Its inputs are SCL and SDA samples that are already synchronized, and one-cycle strobes from an external start/stop detector.

The engine decodes the device select byte, accepts a word address, and passes each accepted write byte to an external page buffer. At the stop that closes a write, it requests the internal programming cycle. Reads are served through a synchronous memory port with one cycle of latency, and the engine shifts the data out MSB first. It owns the word address pointer, so it supports current-address, random and sequential reads.

SDA is driven through an open-drain enable. That enable only changes a fixed number of system clocks after SCL has gone low. This preserves the data hold time and ensures the block never creates a false start or stop.

Parameters set the array size as a word address width of 7 to 11 bits. Select bits that the array size frees become upper word address bits, one 256-byte block per value. Parameters also set the page size and the output hold delay.

Top module: `eeprom_slv_engine`

## Requirements
- R1: A select byte is acknowledged only when bits 7..4 equal 1010 and each of bits 3..1 not used as a block bit equals its strap pin (bit 3 to pin 2, bit 2 to pin 1, bit 1 to pin 0). On a mismatch the engine never drives SDA until the next start or stop.
- R2: When the word address is wider than 8 bits, the low select bits starting at bit 1 become the word address bits above bit 7, and the matching strap pins are ignored. With the default 9-bit width, select bit 1 is address bit 8 and pin 0 is a don't-care.
- R3: A write is performed in three steps:
  - A write select (bit 0 = 0) is acknowledged, then the word address, then each data byte.
  - Every data byte appears once on the page buffer port, with its target address.
  - A stop that follows at least one accepted data byte pulses the write-cycle request for one clock.
- R4: Within a write, the pointer advances after each data byte only inside its page of 2^PAGE_BITS bytes (16 by default). The low bits wrap, so extra bytes land back at the start of the same page.
- R5: While the external write-busy input is high, the select byte is not acknowledged, for both read and write selects. Once busy falls, the same select is acknowledged.
- R6: While write protect is high, the select byte and word address are acknowledged but data bytes are not. Nothing reaches the page buffer and no write cycle is requested at the stop.
- R7: A random read consists of a write select, a word address, a repeated start and a read select (bit 0 = 1). It returns the byte at the loaded address.
- R8: A current-address read returns the byte after the last one accessed, whether that access was a read or a write.
- R9: After each read byte the engine releases SDA and samples the ninth clock. If the master acknowledges, the pointer advances across the whole array and the next byte follows. The pointer wraps from the last address to 0.
- R10: If the master does not acknowledge a read byte, the engine stops driving and ignores SCL until a start or stop.
- R11: A start at any point, including in the middle of a byte, aborts the transfer and begins select-byte reception. A stop returns the engine to idle.
- R12: The SDA enable changes only on the (HOLD_CLKS+1)-th clock edge that samples SCL low after a falling edge. It never changes while SCL is high, except for the immediate release at a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_s | input | 1 | Synchronized SCL level |
| sda_s | input | 1 | Synchronized SDA level (wired bus value) |
| start_det | input | 1 | One-cycle strobe: start condition seen |
| stop_det | input | 1 | One-cycle strobe: stop condition seen |
| dev_pins | input | 3 | Strapped device address pins |
| wp | input | 1 | Write protect, high blocks writes |
| wr_busy | input | 1 | Internal programming cycle in progress |
| sda_oe | output | 1 | High pulls SDA low |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid one clock after request |
| wbuf_valid | output | 1 | Page buffer write strobe |
| wbuf_addr | output | AW | Page buffer target address |
| wbuf_data | output | 8 | Page buffer data byte |
| wcycle_go | output | 1 | One-cycle request to start the write cycle |

## Verification
The bench uses a write that runs past the end of a page to check the page wrap. A design that carried into the upper address bits would corrupt the next page. A sequential read over the last array address checks the wrap to 0, which a truncated pointer would miss.

The bench polls immediately after a write to confirm the select is refused while busy. It also writes under protect, where an acknowledged data byte or a spurious write-cycle request would show up at the ports.

A master NACK is followed by extra clocks to prove the engine stays off the bus. A start in the middle of a byte must leave the next random read intact. Every SDA enable edge is timed against the SCL falling edge, which catches a design that drives too early or changes SDA while SCL is high.

// File: rtl/esl_pkg.sv
package esl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_WADDR,
      ST_WDATA,
      ST_RDATA,
      ST_IGN
   } esl_st_e;

   localparam logic [3:0] DEV_ID_DEFAULT = 4'b1010;
endpackage

// File: rtl/esl_sel_match.sv
module esl_sel_match #(
   parameter int         AW     = 9,
   parameter logic [3:0] DEV_ID = 4'b1010,
   parameter int         BB     = (AW > 8) ? AW - 8 : 0,
   parameter int         BBW    = (BB > 0) ? BB : 1
) (
   input  logic [7:1]     sel,
   input  logic [2:0]     pins,
   output logic           hit,
   output logic [BBW-1:0] blk
);
   logic [2:0] bit_ok;
   logic       unused_pins;

   assign unused_pins = ^pins;

   for (genvar i = 0; i < 3; i++) begin : g_bit
      if (i < BB) begin : g_blk
         assign bit_ok[i] = 1'b1;
         assign blk[i]    = sel[i+1];
      end else begin : g_pin
         assign bit_ok[i] = (sel[i+1] == pins[i]);
      end
   end

   if (BB == 0) begin : g_noblk
      assign blk = '0;
   end

   assign hit = (sel[7:4] == DEV_ID) && (&bit_ok);
endmodule

// File: rtl/esl_out_hold.sv
module esl_out_hold #(
   parameter int HOLD_CLKS = 3,
   parameter int CW        = $clog2(HOLD_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tgt,
   input  logic drop,
   output logic oe
);
   logic [CW-1:0] left;
   logic          armed;
   logic          tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left  <= '0;
         armed <= 1'b0;
         tgt_q <= 1'b0;
         oe    <= 1'b0;
      end else if (drop) begin
         armed <= 1'b0;
         oe    <= 1'b0;
      end else if (load) begin
         tgt_q <= tgt;
         left  <= CW'(HOLD_CLKS - 1);
         armed <= 1'b1;
      end else if (armed) begin
         if (left == CW'(1)) begin
            oe    <= tgt_q;
            armed <= 1'b0;
         end else begin
            left <= left - CW'(1);
         end
      end
   end
endmodule

// File: rtl/eeprom_slv_engine.sv
module eeprom_slv_engine #(
   parameter int         AW        = 9,
   parameter int         PAGE_BITS = 4,
   parameter int         HOLD_CLKS = 3,
   parameter logic [3:0] DEV_ID    = esl_pkg::DEV_ID_DEFAULT
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [2:0]    dev_pins,
   input  logic          wp,
   input  logic          wr_busy,
   output logic          sda_oe,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_rd_addr,
   input  logic [7:0]    mem_rd_data,
   output logic          wbuf_valid,
   output logic [AW-1:0] wbuf_addr,
   output logic [7:0]    wbuf_data,
   output logic          wcycle_go
);
   import esl_pkg::*;

   localparam int BB  = (AW > 8) ? AW - 8 : 0;
   localparam int BBW = (BB > 0) ? BB : 1;
   localparam int PB  = PAGE_BITS;

   if (AW < 7 || AW > 11) begin : g_bad_aw
      $error("AW must lie in 7..11");
   end
   if (PB < 1 || PB >= AW) begin : g_bad_pb
      $error("PAGE_BITS must lie in 1..AW-1");
   end
   if (HOLD_CLKS < 2) begin : g_bad_hold
      $error("HOLD_CLKS must be at least 2");
   end

   esl_st_e        st;
   logic [3:0]     cnt;
   logic [7:0]     shreg, tx;
   logic [AW-1:0]  ptr, waddr_load;
   logic [BBW-1:0] blk_q, sel_blk;
   logic           rd_mode, mack, wr_pend, rd_req, rd_cap;
   logic           hold_load, hold_tgt, sel_hit;
   logic           scl_q, scl_rise, scl_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_s;
   end
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;

   esl_sel_match #(.AW(AW), .DEV_ID(DEV_ID), .BB(BB), .BBW(BBW)) u_match (
      .sel  (shreg[7:1]),
      .pins (dev_pins),
      .hit  (sel_hit),
      .blk  (sel_blk)
   );

   if (BB > 0) begin : g_wide
      assign waddr_load = {blk_q[BB-1:0], shreg};
   end else begin : g_narrow
      assign waddr_load = shreg[AW-1:0];
   end

   esl_out_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hold_load),
      .tgt   (hold_tgt),
      .drop  (start_det | stop_det),
      .oe    (sda_oe)
   );

   assign mem_rd_en   = rd_req;
   assign mem_rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         tx         <= '0;
         ptr        <= '0;
         blk_q      <= '0;
         rd_mode    <= 1'b0;
         mack       <= 1'b0;
         wr_pend    <= 1'b0;
         rd_req     <= 1'b0;
         rd_cap     <= 1'b0;
         hold_load  <= 1'b0;
         hold_tgt   <= 1'b0;
         wbuf_valid <= 1'b0;
         wbuf_addr  <= '0;
         wbuf_data  <= '0;
         wcycle_go  <= 1'b0;
      end else begin
         hold_load  <= 1'b0;
         wbuf_valid <= 1'b0;
         wcycle_go  <= 1'b0;
         rd_req     <= 1'b0;
         rd_cap     <= rd_req;
         if (rd_cap) tx <= mem_rd_data;

         if (start_det) begin
            st      <= ST_SEL;
            cnt     <= '0;
            wr_pend <= 1'b0;
         end else if (stop_det) begin
            wcycle_go <= wr_pend;
            wr_pend   <= 1'b0;
            st        <= ST_IDLE;
            cnt       <= '0;
         end else if (st != ST_IDLE && st != ST_IGN) begin
            if (scl_rise) begin
               if (cnt < 4'd9) cnt <= cnt + 4'd1;
               if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
               if (cnt == 4'd8) begin
                  mack <= ~sda_s;
                  if (st == ST_RDATA && !sda_s) rd_req <= 1'b1;
               end
            end else if (scl_fall) begin
               if (cnt == 4'd8) begin
                  case (st)
                     ST_SEL: begin
                        if (sel_hit && !wr_busy) begin
                           hold_load <= 1'b1;
                           hold_tgt  <= 1'b1;
                           rd_mode   <= shreg[0];
                           blk_q     <= sel_blk;
                           if (shreg[0]) rd_req <= 1'b1;
                        end else begin
                           st <= ST_IGN;
                        end
                     end
                     ST_WADDR: begin
                        hold_load <= 1'b1;
                        hold_tgt  <= 1'b1;
                        ptr       <= waddr_load;
                     end
                     ST_WDATA: begin
                        if (wp) begin
                           st <= ST_IGN;
                        end else begin
                           hold_load  <= 1'b1;
                           hold_tgt   <= 1'b1;
                           wbuf_valid <= 1'b1;
                           wbuf_addr  <= ptr;
                           wbuf_data  <= shreg;
                           wr_pend    <= 1'b1;
                           ptr        <= {ptr[AW-1:PB], ptr[PB-1:0] + PB'(1)};
                        end
                     end
                     ST_RDATA: begin
                        hold_load <= 1'b1;
                        hold_tgt  <= 1'b0;
                        ptr       <= ptr + AW'(1);
                     end
                     default: ;
                  endcase
               end else if (cnt == 4'd9) begin
                  cnt       <= '0;
                  hold_load <= 1'b1;
                  hold_tgt  <= 1'b0;
                  case (st)
                     ST_SEL: begin
                        if (rd_mode) begin
                           st       <= ST_RDATA;
                           hold_tgt <= ~tx[7];
                        end else begin
                           st <= ST_WADDR;
                        end
                     end
                     ST_WADDR: st <= ST_WDATA;
                     ST_RDATA: begin
                        if (mack) hold_tgt <= ~tx[7];
                        else      st       <= ST_IGN;
                     end
                     default: ;
                  endcase
               end else if (cnt != 4'd0 && st == ST_RDATA) begin
                  hold_load <= 1'b1;
                  hold_tgt  <= ~tx[3'd7 - cnt[2:0]];
               end
            end
         end
      end
   end
endmodule

// File: rtl/esl_chk.sv
module esl_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic wp,
   input logic sda_oe,
   input logic wbuf_valid,
   input logic wcycle_go,
   input logic in_ign
);
   // R12
   oe_edge_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_s));

   // R6
   no_wbuf_under_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wbuf_valid |-> !$past(wp));

   // R3
   go_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcycle_go |-> $past(stop_det));

   // R1
   quiet_when_ignoring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ign |-> !sda_oe);

   // R11
   release_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);
endmodule

bind eeprom_slv_engine esl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .start_det  (start_det),
   .stop_det   (stop_det),
   .wp         (wp),
   .sda_oe     (sda_oe),
   .wbuf_valid (wbuf_valid),
   .wcycle_go  (wcycle_go),
   .in_ign     (st == esl_pkg::ST_IGN)
);

// File: tb/sim_eeprom_slv_engine.sv
module sim_eeprom_slv_engine;
   localparam int AW   = 9;
   localparam int HOLD = 3;
   localparam int HP   = 8;
   localparam int NW   = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic start_det = 1'b0, stop_det = 1'b0;
   logic wp = 1'b0;
   logic sda_oe, mem_rd_en, wbuf_valid, wcycle_go;
   logic [AW-1:0] mem_rd_addr, wbuf_addr;
   logic [7:0] mem_rd_data = 8'h00, wbuf_data;
   logic sda_s;
   int busy_cnt = 0;
   logic wr_busy;

   always #10 clk = ~clk;

   assign sda_s   = sda_m & ~sda_oe;
   assign wr_busy = (busy_cnt != 0);

   eeprom_slv_engine #(.AW(AW), .PAGE_BITS(4), .HOLD_CLKS(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_m), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det), .dev_pins(3'b101),
      .wp(wp), .wr_busy(wr_busy), .sda_oe(sda_oe),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .wbuf_valid(wbuf_valid), .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
      .wcycle_go(wcycle_go)
   );

   logic [7:0] mem [NW];
   logic [7:0] ref_mem [NW];
   logic [16:0] pend_q [$];
   int ref_ptr = 0;
   int go_cnt = 0;
   int nchk = 0, nfail = 0;
   bit done = 0;

   // array and page buffer stand-in
   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
      if (wbuf_valid) pend_q.push_back({wbuf_addr, wbuf_data});
      if (wcycle_go) begin
         for (int k = 0; k < pend_q.size(); k++) mem[pend_q[k][16:8]] = pend_q[k][7:0];
         pend_q.delete();
         go_cnt   <= go_cnt + 1;
         busy_cnt <= 400;
      end else if (busy_cnt > 0) begin
         busy_cnt <= busy_cnt - 1;
      end
   end

   // per-clock monitors: output timing and quiet windows
   int low_edges = 0;
   int hold_seen = 0, hold_bad = 0, hi_change = 0, quiet_hits = 0;
   bit quiet_win = 0;
   logic prev_oe = 1'b0, prev_scl = 1'b1, prev_sp = 1'b0;
   always @(posedge clk) begin
      if (!scl_m) low_edges <= low_edges + 1;
      else        low_edges <= 0;
   end
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== prev_oe && !prev_sp) begin
            if (scl_m && prev_scl) hi_change++;
            if (!scl_m) begin
               hold_seen++;
               if (low_edges != HOLD + 1) hold_bad++;
            end
         end
         if (quiet_win && sda_oe) quiet_hits++;
      end
      prev_oe  = sda_oe;
      prev_scl = scl_m;
      prev_sp  = start_det | stop_det;
   end

   task automatic chk(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      if (!scl_m) begin
         sda_m = 1'b1; tick(HP);
         scl_m = 1'b1; tick(HP);
      end
      sda_m = 1'b0; start_det = 1'b1; tick(1);
      start_det = 1'b0; tick(HP);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic bstop();
      sda_m = 1'b0; tick(HP);
      scl_m = 1'b1; tick(HP);
      sda_m = 1'b1; stop_det = 1'b1; tick(1);
      stop_det = 1'b0; tick(HP);
   endtask

   task automatic send_bits(logic [7:0] b, int n);
      for (int i = 0; i < n; i++) begin
         sda_m = b[7-i]; tick(HP);
         scl_m = 1'b1; tick(HP);
         scl_m = 1'b0; tick(2);
      end
   endtask

   task automatic send_byte(logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; tick(HP);
      scl_m = 1'b1; tick(HP/2);
      ack = !sda_s; tick(HP/2);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic recv_byte(bit mack, output logic [7:0] d);
      sda_m = 1'b1;
      d = 8'h00;
      for (int i = 0; i < 8; i++) begin
         tick(HP);
         scl_m = 1'b1; tick(HP/2);
         d = {d[6:0], sda_s}; tick(HP/2);
         scl_m = 1'b0; tick(2);
      end
      sda_m = !mack; tick(HP);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] sel(bit b0, bit rd);
      return 8'hA8 | {6'b0, b0, 1'b0} | {7'b0, rd};
   endfunction

   task automatic wait_idle();
      while (wr_busy) tick(1);
      tick(5);
   endtask

   task automatic wr_page(int addr, logic [7:0] d[$], bit data_ok, string req);
      bit a;
      bstart();
      send_byte(sel(addr[8], 1'b0), a); chk(a, req, a, 1);
      send_byte(addr[7:0], a);          chk(a, req, a, 1);
      foreach (d[i]) begin
         send_byte(d[i], a);
         chk(a == data_ok, req, a, data_ok);
         if (data_ok) ref_mem[(addr & ~15) | ((addr + i) & 15)] = d[i];
      end
      ref_ptr = data_ok ? ((addr & ~15) | ((addr + d.size()) & 15)) : addr;
      bstop();
   endtask

   task automatic rd_body(int n, string req);
      bit a;
      logic [7:0] d;
      send_byte(sel(1'b0, 1'b1), a); chk(a, req, a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, d);
         chk(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
         ref_ptr = (ref_ptr + 1) % NW;
      end
   endtask

   task automatic rd_rand(int addr, int n, string req);
      bit a;
      bstart();
      send_byte(sel(addr[8], 1'b0), a); chk(a, req, a, 1);
      send_byte(addr[7:0], a);          chk(a, req, a, 1);
      ref_ptr = addr;
      bstart();
      rd_body(n, req);
      bstop();
   endtask

   task automatic rd_cur(int n, string req);
      bstart();
      rd_body(n, req);
      bstop();
   endtask

   initial begin
      bit a;
      int g0, polls, nacks;
      logic [7:0] d;
      for (int i = 0; i < NW; i++) begin
         mem[i]     = 8'((i * 37 + 11) & 255);
         ref_mem[i] = 8'((i * 37 + 11) & 255);
      end
      tick(4);
      rst_n = 1'b1;
      tick(4);
      chk(sda_oe == 1'b0 && wcycle_go == 1'b0 && wbuf_valid == 1'b0,
          "reset", {sda_oe, wcycle_go, wbuf_valid}, 0);

      // R1: mismatching strap bits, engine must stay silent
      bstart();
      quiet_win = 1;
      send_byte(8'hA4, a); chk(!a, "R1 mismatch nack", a, 0);
      send_byte(8'h00, a); chk(!a, "R1 ignore next byte", a, 0);
      quiet_win = 0;
      chk(quiet_hits == 0, "R1 no drive while ignoring", quiet_hits, 0);
      bstop();

      // R3: byte write
      g0 = go_cnt;
      wr_page(12'h055, '{8'h3C}, 1'b1, "R3 byte write ack");
      tick(3);
      chk(go_cnt == g0 + 1, "R3 write cycle request", go_cnt, g0 + 1);

      // R5: acknowledge polling while busy
      polls = 0; nacks = 0; a = 0;
      while (!a && polls < 40) begin
         bstart();
         send_byte(sel(1'b0, 1'b0), a);
         if (!a) nacks++;
         bstop();
         polls++;
      end
      chk(nacks > 0, "R5 nack while busy", nacks, 1);
      chk(a, "R5 ack after busy", a, 1);
      wait_idle();

      // R8: current address after write
      ref_ptr = 12'h056;
      rd_cur(1, "R8 current read");
      // R7: random read
      rd_rand(12'h055, 1, "R7 random read");

      // R4 + R2: page write in block 1 crossing page end
      wr_page(12'h11E, '{8'hA1, 8'hA2, 8'hA3}, 1'b1, "R4 page write ack");
      wait_idle();
      rd_rand(12'h110, 1, "R4 page wrap to page start");
      rd_rand(12'h11E, 2, "R2 block bit high");
      rd_rand(12'h01E, 1, "R2 block 0 untouched");

      // R9: sequential read over end of array
      rd_rand(12'h1FE, 4, "R9 sequential wrap");

      // R6: write protect
      wp = 1'b1;
      g0 = go_cnt;
      wr_page(12'h020, '{8'h5A, 8'h5B}, 1'b0, "R6 wp data nack");
      tick(3);
      chk(go_cnt == g0, "R6 no write cycle", go_cnt, g0);
      chk(pend_q.size() == 0, "R6 no buffer entry", pend_q.size(), 0);
      wp = 1'b0;
      rd_rand(12'h020, 1, "R6 data unchanged");

      // R10: master nack ends read, engine quiet after
      bstart();
      send_byte(sel(1'b0, 1'b1), a); chk(a, "R10 read select", a, 1);
      recv_byte(1'b0, d);
      quiet_win = 1; quiet_hits = 0;
      send_byte(8'h00, a); chk(!a, "R10 quiet after nack", a, 0);
      quiet_win = 0;
      chk(quiet_hits == 0, "R10 no drive after nack", quiet_hits, 0);
      bstop();

      // R11: start in mid byte aborts, next transfer works
      bstart();
      send_bits(sel(1'b0, 1'b0), 4);
      bstart();
      send_byte(sel(1'b0, 1'b0), a); chk(a, "R11 select after abort", a, 1);
      send_byte(8'h55, a);           chk(a, "R11 address after abort", a, 1);
      ref_ptr = 12'h055;
      bstart();
      rd_body(1, "R11 read after abort");
      bstop();

      // R12: output timing
      chk(hold_seen > 0 && hold_bad == 0, "R12 hold delay", hold_bad, 0);
      chk(hi_change == 0, "R12 no change while SCL high", hi_change, 0);

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule